// File: doc/BRIEF.md
# Backlight PWM Generator with Prescaler

This block produces the pulse-width-modulated enable for a display backlight. A single control word holds the PWM period in its upper half and the active (high) time in its lower half. Both values count time-base events. A prescaler divides the input clock to make those events. A mode input picks one of two divide ratios, one for each possible clock source. Software writes the word through a minimal register port. The word can be read back at any time.

A new word does not disturb the PWM cycle in progress. It is held as the pending setting. The active copy of the period, the duty and the mode is loaded from it only when the current cycle ends, so changes in brightness appear without glitches.

The sequencer is a three-state machine:
- `ST_IDLE`: output low, prescaler held.
- `ST_HIGH`: output high.
- `ST_LOW`: output low.

Its transitions are:
- IDLE→HIGH or IDLE→LOW: the pending period is non-zero. The target is LOW when the pending duty is zero.
- HIGH→LOW: the event count reaches the duty within a cycle.
- HIGH/LOW→HIGH/LOW/IDLE: the cycle boundary, where the next state is chosen from the newly loaded setting.
- Any state→IDLE: the boundary loads a zero period.

Top module: `blpwm_backlight`

## Requirements
- R1: After reset the control word reads as zero and the PWM output is low.
- R2: The read port returns the most recently written word from the clock edge after the write, even while the active copy still holds older values.
- R3: Bits 31:16 of the word give the period P in events and bits 15:0 give the duty D in events. Each cycle lasts P events. The output is high for the first D events of the cycle and low for the rest.
- R4: With the mode input at 0 one event is CORE_DIV input clocks (default 128). With the mode input at 1 one event is LP_DIV input clocks (default 16).
- R5: A duty of zero with a non-zero period keeps the output low for the whole cycle.
- R6: A duty equal to the period keeps the output high for the whole cycle.
- R7: A duty greater than the period is clamped, so the output is high for the whole cycle.
- R8: New period, duty and mode values written during a cycle take effect only from the first clock of the next cycle. The old cycle completes unchanged and the new cycle follows with no gap.
- R9: A period of zero holds the output low and stops the event counting.
- R10: From the idle state, a write with a non-zero period starts a cycle on the clock edge after the write edge, beginning with the first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_clk_mode | input | 1 | 0: divide by CORE_DIV, 1: divide by LP_DIV; latched at cycle start |
| cfg_we | input | 1 | Write enable for the control word |
| cfg_wdata | input | PERIOD_W+DUTY_W (32) | Control word to write: period high, duty low |
| cfg_rdata | output | PERIOD_W+DUTY_W (32) | Most recently written control word |
| bl_pwm | output | 1 | Backlight PWM output |

## Verification
The bench builds the block with CORE_DIV = 8 and LP_DIV = 2, while keeping 16-bit period and duty fields. With these ratios, whole PWM cycles take tens of clocks instead of thousands. This lets a clock-by-clock expected waveform cover several cycles, and it covers switches between the two ratios at a cycle boundary. The field widths stay at their full size, so the bit positions of period and duty are exercised exactly as in the default build.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;

    // Sequencer states of the backlight PWM generator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } blpwm_state_e;

endpackage

// File: rtl/blpwm_prescale.sv
module blpwm_prescale #(
    parameter int DIV_A = 128,
    parameter int DIV_B = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_b,
    output logic tick
);
    localparam int DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;
    localparam logic [CW-1:0] LIM_A = CW'(DIV_A - 1);
    localparam logic [CW-1:0] LIM_B = CW'(DIV_B - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Ratio select: a single constant when both sources divide alike
    generate
        if (DIV_A == DIV_B) begin : g_one_ratio
            assign limit = LIM_A;
        end else begin : g_two_ratio
            assign limit = sel_b ? LIM_B : LIM_A;
        end
    endgenerate

    assign tick = en && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R4: the divider never runs past the selected ratio
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R4: an idle prescaler restarts from zero
    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);

    generate
        if (DIV_A > 1 && DIV_B > 1) begin : g_gap_chk
            // R4: events are separated by at least one clock
            p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/blpwm_regs.sv
module blpwm_regs #(
    parameter int PW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW+DW-1:0] wr_data,
    input  logic          src_sel,
    input  logic          load,
    output logic [PW+DW-1:0] rd_data,
    output logic [PW-1:0] pend_period,
    output logic [DW-1:0] pend_duty,
    output logic [PW-1:0] act_period,
    output logic [DW-1:0] act_duty,
    output logic          act_lp
);
    localparam int WW = PW + DW;

    logic [WW-1:0] word_q;
    logic [PW-1:0] per_q;
    logic [DW-1:0] dut_q;
    logic          lp_q;

    // Software-visible word: always the latest write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data;
        end
    end

    assign rd_data     = word_q;
    assign pend_period = word_q[WW-1:DW];
    assign pend_duty   = word_q[DW-1:0];

    // Active copy: refreshed only when the sequencer asks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
            dut_q <= '0;
            lp_q  <= 1'b0;
        end else if (load) begin
            per_q <= pend_period;
            dut_q <= pend_duty;
            lp_q  <= src_sel;
        end
    end

    assign act_period = per_q;
    assign act_duty   = dut_q;
    assign act_lp     = lp_q;

    // R2: a write is visible on the read port one edge later
    p_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R8: the active setting moves only on a load request
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_period) && $stable(act_duty) && $stable(act_lp)));

endmodule

// File: rtl/blpwm_seq.sv
module blpwm_seq
    import blpwm_pkg::*;
#(
    parameter int PW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] pend_period,
    input  logic [DW-1:0] pend_duty,
    input  logic [PW-1:0] act_period,
    input  logic [DW-1:0] act_duty,
    output logic          load,
    output logic          run,
    output logic          pwm_out
);
    localparam int CW = ((PW > DW) ? PW : DW) + 1;

    blpwm_state_e  state_q, state_d;
    logic [PW-1:0] ev_q, ev_d;
    logic [CW-1:0] ev_next;
    logic          last_ev;
    logic          boundary;
    logic          duty_hit;

    assign ev_next  = CW'(ev_q) + CW'(1);
    assign last_ev  = (ev_next == CW'(act_period));
    assign duty_hit = (ev_next == CW'(act_duty));
    assign run      = (state_q != ST_IDLE);
    assign boundary = run && tick && last_ev;
    assign load     = !run || boundary;

    // Next-state and event counter logic
    always_comb begin
        state_d = state_q;
        ev_d    = ev_q;
        if (load) begin
            ev_d = '0;
            if (pend_period == '0) begin
                state_d = ST_IDLE;
            end else if (pend_duty == '0) begin
                state_d = ST_LOW;
            end else begin
                state_d = ST_HIGH;
            end
        end else if (tick) begin
            ev_d = ev_q + PW'(1);
            unique case (state_q)
                ST_HIGH: if (duty_hit) state_d = ST_LOW;
                ST_LOW:  state_d = ST_LOW;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ev_q    <= '0;
        end else begin
            state_q <= state_d;
            ev_q    <= ev_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_HIGH: pwm_out = 1'b1;
            ST_LOW:  pwm_out = 1'b0;
            default: pwm_out = 1'b0;
        endcase
    end

    // R3: the event count stays inside the active period
    p_ev_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> CW'(ev_q) < CW'(act_period));

    // R5: zero duty never drives the output high
    p_duty0_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_duty == '0) |-> !pwm_out);

    // R6 and R7: duty at or above the period holds the output high
    p_full_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_period != '0 && CW'(act_duty) >= CW'(act_period)) |-> pwm_out);

    // R9: a zero active period keeps the output low and the counter idle
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_period == '0) |-> (!pwm_out && !tick));

endmodule

// File: rtl/blpwm_backlight.sv
module blpwm_backlight #(
    parameter int PERIOD_W = 16,
    parameter int DUTY_W   = 16,
    parameter int CORE_DIV = 128,
    parameter int LP_DIV   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lp_clk_mode,
    input  logic                       cfg_we,
    input  logic [PERIOD_W+DUTY_W-1:0] cfg_wdata,
    output logic [PERIOD_W+DUTY_W-1:0] cfg_rdata,
    output logic                       bl_pwm
);
    logic [PERIOD_W-1:0] pend_period, act_period;
    logic [DUTY_W-1:0]   pend_duty, act_duty;
    logic                act_lp;
    logic                load;
    logic                run;
    logic                tick;

    blpwm_regs #(.PW(PERIOD_W), .DW(DUTY_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_data     (cfg_wdata),
        .src_sel     (lp_clk_mode),
        .load        (load),
        .rd_data     (cfg_rdata),
        .pend_period (pend_period),
        .pend_duty   (pend_duty),
        .act_period  (act_period),
        .act_duty    (act_duty),
        .act_lp      (act_lp)
    );

    blpwm_prescale #(.DIV_A(CORE_DIV), .DIV_B(LP_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .sel_b (act_lp),
        .tick  (tick)
    );

    blpwm_seq #(.PW(PERIOD_W), .DW(DUTY_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .pend_period (pend_period),
        .pend_duty   (pend_duty),
        .act_period  (act_period),
        .act_duty    (act_duty),
        .load        (load),
        .run         (run),
        .pwm_out     (bl_pwm)
    );

endmodule

// File: tb/blpwm_backlight_bench.sv
module blpwm_backlight_bench;
    localparam int CORE = 8;
    localparam int LP   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_clk_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bl_pwm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;
    exp_t q[$];
    exp_t cur;

    always #4 clk = ~clk;

    blpwm_backlight #(.PERIOD_W(16), .DUTY_W(16), .CORE_DIV(CORE), .LP_DIV(LP)) u_blpwm_backlight (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_clk_mode (lp_clk_mode),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .bl_pwm      (bl_pwm)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compare each clock against the scoreboard queue
    always @(negedge clk) begin
        if (q.size() > 0) begin
            cur = q.pop_front();
            chk(bl_pwm === cur.v, cur.tag, {31'd0, bl_pwm}, {31'd0, cur.v});
        end
    end

    task automatic push_val(input logic v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Expected waveform of n whole cycles (R3 shape)
    task automatic push_cycle(input int p, input int d, input int r, input string tag, input int n);
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < p * r; i++) begin
                push_val((d >= p) ? 1'b1 : (i < d * r), tag);
            end
        end
    endtask

    task automatic wait_left(input int n);
        while (q.size() > n) @(negedge clk);
    endtask

    task automatic wr(input logic mode, input logic [15:0] per, input logic [15:0] dut);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_wdata   = {per, dut};
        lp_clk_mode = mode;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        chk(cfg_rdata === {per, dut}, "R2", cfg_rdata, {per, dut});
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(cfg_rdata === 32'd0, "R1", cfg_rdata, 32'd0);
        chk(bl_pwm === 1'b0, "R1", {31'd0, bl_pwm}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bl_pwm === 1'b0, "R1", {31'd0, bl_pwm}, 32'd0);

        // R10 start from idle, R3 shape, R4 core ratio
        wr(1'b0, 16'd4, 16'd1);
        push_val(1'b0, "R10");
        push_cycle(4, 1, CORE, "R3", 1);
        push_cycle(4, 1, CORE, "R4", 1);

        // R8: duty and mode change mid-cycle, applied at the boundary
        wait_left(16);
        wr(1'b1, 16'd4, 16'd3);
        push_cycle(4, 3, LP, "R8", 1);
        push_cycle(4, 3, LP, "R4", 1);

        // R5: zero duty
        wait_left(4);
        wr(1'b1, 16'd4, 16'd0);
        push_cycle(4, 0, LP, "R5", 2);

        // R6: duty equals period
        wait_left(4);
        wr(1'b1, 16'd4, 16'd4);
        push_cycle(4, 4, LP, "R6", 2);

        // R7: duty above period, back to core ratio
        wait_left(4);
        wr(1'b0, 16'd4, 16'd7);
        push_cycle(4, 7, CORE, "R7", 1);

        // R8: period change loads at the boundary
        wait_left(16);
        wr(1'b0, 16'd3, 16'd2);
        push_cycle(3, 2, CORE, "R8", 2);

        // R9: zero period stops the output
        wait_left(12);
        wr(1'b0, 16'd0, 16'd2);
        for (int i = 0; i < 30; i++) push_val(1'b0, "R9");
        wait_left(0);
        repeat (3) @(negedge clk);

        // R10: restart from idle with the fast ratio
        wr(1'b1, 16'd2, 16'd1);
        push_val(1'b0, "R10");
        push_cycle(2, 1, LP, "R10", 3);
        wait_left(0);
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule